// File: doc/BRIEF.md
# Transfer Descriptor Dispatcher

This block is the register-facing front end of a scatter-gather transfer engine. Software fills an eight-word descriptor window with source and destination addresses, a byte length, a burst/sequence word, a stride word and a control word. Writing the control word with its commit bit set turns the staged words into one transfer descriptor and places it in a small queue. The block offers the queued descriptors, oldest first, to a data mover over a valid/ready handshake. It waits for the mover's completion pulse before it offers the next one.

A separate control/status window reports activity, queue depth, completion counts and sticky event flags. It also lets software pause dispatch or start a multi-cycle soft reset. The soft reset empties the queue, withdraws any offer to the mover and signals an abort. It holds an in-progress flag for a fixed number of cycles.

Top module: `sgd_dispatch`

## Requirements
- R1: After the synchronous reset, the status word reads 0x0000_0002 (only the queue-empty bit 1 set), the queue-depth word and both counter words read 0, and `mv_valid` is low.
- R2: Descriptor word index 0/5 hold the source address low/high, 1/6 the destination address low/high, 2 the length, 3 the burst/sequence word, 4 the stride word (bits 15:0 read stride, bits 31:16 write stride), 7 the control word. Control bits 8, 9, 12 and 13 appear on `mv_flags` bits 0, 1, 2 and 3. Every field reaches the mover unchanged.
- R3: A write to descriptor word 7 with bit 31 set queues one descriptor, and the queue depth (CSR word 2, bits 15:0) rises by one in the following cycle. A write to word 7 with bit 31 clear queues nothing.
- R4: Descriptors are offered in the order they were committed. The first is offered one cycle after commit when the mover is idle. `mv_valid` and all descriptor outputs hold steady until `mv_ready` is seen. The next offer comes only after a `mv_done` pulse.
- R5: Status bit 0 (busy) is set whenever the queue is non-empty or a descriptor is offered or executing, and clear otherwise.
- R6: A commit while the queue already holds FIFO_DEPTH descriptors is dropped: the depth is unchanged, and sticky status bit 9 is set.
- R7: Writing ones to status bits 9:0 clears the sticky bits 9 (overflow) and 8 (completion seen). The live bits (0 busy, 1 empty, 2 full, 5 paused, 6 resetting) are not changed by such a write.
- R8: Writing control word (CSR word 1) with bit 1 set starts a soft reset. Status bit 6 and `mv_abort` are high for exactly RST_CYCLES cycles (at least 4). The queue is emptied, `mv_valid` drops, and the pause bit, counters and sticky flags clear.
- R9: A commit written while the soft reset is in progress is discarded and sets no flag.
- R10: Control bit 0 (pause) holds back new offers while set; committed descriptors stay queued and are offered once it clears. Status bit 5 mirrors it.
- R11: CSR word 4 counts committed descriptors in bits 15:0 and completions in bits 31:16. CSR word 3 bits 15:0 count pending responses: each `mv_done` adds one and each write to CSR word 3 retires one (not below zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Control/status window write strobe |
| csr_addr | input | 3 | Control/status word index |
| csr_wdata | input | 32 | Control/status write data |
| csr_rdata | output | 32 | Control/status read data for `csr_addr` (combinational) |
| dsc_wr | input | 1 | Descriptor window write strobe |
| dsc_addr | input | 3 | Descriptor word index |
| dsc_wdata | input | 32 | Descriptor write data |
| mv_valid | output | 1 | Descriptor offered to the data mover |
| mv_ready | input | 1 | Data mover accepts the offered descriptor |
| mv_done | input | 1 | Data mover completion pulse |
| mv_abort | output | 1 | High while a soft reset is in progress |
| mv_rd_addr | output | 64 | Source address |
| mv_wr_addr | output | 64 | Destination address |
| mv_len | output | 32 | Transfer length |
| mv_burst_seq | output | 32 | Burst/sequence word |
| mv_rd_stride | output | 16 | Read stride |
| mv_wr_stride | output | 16 | Write stride |
| mv_flags | output | 4 | {end on length, end on packet end, make packet end, make packet start} |

## Verification
A corrupted queue pointer or count shows up within one cycle in the depth word. It also shows up at the next offer as a descriptor whose fields do not match the words committed. A stuck dispatch state keeps status busy high, or lets `mv_valid` rise before `mv_done`, and this is visible on the first transfer. A wrong reset counter changes the number of cycles that status bit 6 and `mv_abort` stay high. The bench counts those cycles against RST_CYCLES.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    localparam int WORD_W = 32;

    // descriptor window word indices
    localparam logic [2:0] W_RD_LO  = 3'd0;
    localparam logic [2:0] W_WR_LO  = 3'd1;
    localparam logic [2:0] W_LEN    = 3'd2;
    localparam logic [2:0] W_BSEQ   = 3'd3;
    localparam logic [2:0] W_STRIDE = 3'd4;
    localparam logic [2:0] W_RD_HI  = 3'd5;
    localparam logic [2:0] W_WR_HI  = 3'd6;
    localparam logic [2:0] W_CTRL   = 3'd7;

    // control-window word indices
    localparam logic [2:0] C_STATUS = 3'd0;
    localparam logic [2:0] C_CTRL   = 3'd1;
    localparam logic [2:0] C_QLVL   = 3'd2;
    localparam logic [2:0] C_RESP   = 3'd3;
    localparam logic [2:0] C_SEQ    = 3'd4;

    // descriptor control bits
    localparam int B_COMMIT  = 31;
    localparam int B_SOP     = 8;
    localparam int B_EOP     = 9;
    localparam int B_END_EOP = 12;
    localparam int B_END_LEN = 13;

    // status bits
    localparam int S_BUSY  = 0;
    localparam int S_EMPTY = 1;
    localparam int S_FULL  = 2;
    localparam int S_PAUSE = 5;
    localparam int S_RST   = 6;
    localparam int S_DONE  = 8;
    localparam int S_OVF   = 9;

    // control bits
    localparam int K_PAUSE = 0;
    localparam int K_RESET = 1;

    typedef struct packed {
        logic [63:0] rd_addr;
        logic [63:0] wr_addr;
        logic [31:0] len;
        logic [31:0] burst_seq;
        logic [15:0] wr_stride;
        logic [15:0] rd_stride;
        logic [3:0]  flags;
    } xfer_desc_t;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_OFFER = 2'd1,
        MV_RUN   = 2'd2
    } mv_state_e;

    function automatic xfer_desc_t build_desc(input logic [6:0][WORD_W-1:0] w,
                                              input logic [WORD_W-1:0] ctl);
        xfer_desc_t d;
        d.rd_addr   = {w[W_RD_HI], w[W_RD_LO]};
        d.wr_addr   = {w[W_WR_HI], w[W_WR_LO]};
        d.len       = w[W_LEN];
        d.burst_seq = w[W_BSEQ];
        d.rd_stride = w[W_STRIDE][15:0];
        d.wr_stride = w[W_STRIDE][31:16];
        d.flags     = {ctl[B_END_LEN], ctl[B_END_EOP], ctl[B_EOP], ctl[B_SOP]};
        return d;
    endfunction

endpackage

// File: rtl/sgd_stage.sv
module sgd_stage
    import sgd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              commit,
    output xfer_desc_t        desc
);
    logic [6:0][WORD_W-1:0] words;

    always_ff @(posedge clk) begin
        if (rst) begin
            words <= '0;
        end else if (wr && addr != W_CTRL) begin
            words[addr] <= wdata;
        end
    end

    assign commit = wr && (addr == W_CTRL) && wdata[B_COMMIT];
    assign desc   = build_desc(words, wdata);
endmodule

// File: rtl/sgd_fifo.sv
module sgd_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             push_ok, pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= nxt(wptr);
            if (pop_ok)  rptr <= nxt(rptr);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wptr] <= din;
    end

    a_r6_bounded: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    a_r6_full_drop: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/sgd_rstseq.sv
module sgd_rstseq #(
    parameter int CYCLES = 6,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic busy
);
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            left <= '0;
        end else if (trigger) begin
            busy <= 1'b1;
            left <= CW'(CYCLES - 1);
        end else if (busy) begin
            if (left == '0) busy <= 1'b0;
            else            left <= left - 1'b1;
        end
    end

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && left != '0) |=> busy);

    a_r8_min_len: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);
endmodule

// File: rtl/sgd_dispatch.sv
module sgd_dispatch
    import sgd_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int RST_CYCLES = 6,
    parameter int LVL_W      = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_wr,
    input  logic [2:0]  csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic        dsc_wr,
    input  logic [2:0]  dsc_addr,
    input  logic [31:0] dsc_wdata,
    output logic        mv_valid,
    input  logic        mv_ready,
    input  logic        mv_done,
    output logic        mv_abort,
    output logic [63:0] mv_rd_addr,
    output logic [63:0] mv_wr_addr,
    output logic [31:0] mv_len,
    output logic [31:0] mv_burst_seq,
    output logic [15:0] mv_rd_stride,
    output logic [15:0] mv_wr_stride,
    output logic [3:0]  mv_flags
);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int DESC_W = $bits(xfer_desc_t);
    localparam logic [LVL_W-1:0] LVL_MAX = '1;

    logic        commit, push, pop, rst_trig, rst_busy, done_evt;
    logic        q_full, q_empty, paused, ovf_flag, done_flag, resp_ret;
    logic [CNT_W-1:0] q_count;
    xfer_desc_t  staged, q_head, exec_d;
    logic [DESC_W-1:0] q_head_bits;
    mv_state_e   state;
    logic [LVL_W-1:0] n_commit, n_done, n_resp;
    logic [31:0] status;

    sgd_stage u_stage (
        .clk(clk), .rst(rst), .wr(dsc_wr), .addr(dsc_addr), .wdata(dsc_wdata),
        .commit(commit), .desc(staged)
    );

    assign rst_trig = csr_wr && (csr_addr == C_CTRL) && csr_wdata[K_RESET];
    assign push     = commit && !rst_busy && !rst_trig;

    sgd_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DESC_W)) u_fifo (
        .clk(clk), .rst(rst), .flush(rst_trig || rst_busy),
        .push(push), .din(staged), .pop(pop),
        .head(q_head_bits), .count(q_count), .full(q_full), .empty(q_empty)
    );
    assign q_head = xfer_desc_t'(q_head_bits);

    sgd_rstseq #(.CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .rst(rst), .trigger(rst_trig), .busy(rst_busy)
    );

    assign pop      = (state == MV_IDLE) && !q_empty && !paused && !rst_busy && !rst_trig;
    assign done_evt = (state == MV_RUN) && mv_done && !rst_trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= MV_IDLE;
            exec_d <= '0;
        end else if (rst_trig || rst_busy) begin
            state  <= MV_IDLE;
        end else begin
            unique case (state)
                MV_IDLE:  if (pop) begin
                              state  <= MV_OFFER;
                              exec_d <= q_head;
                          end
                MV_OFFER: if (mv_ready) state <= MV_RUN;
                MV_RUN:   if (mv_done)  state <= MV_IDLE;
                default:  state <= MV_IDLE;
            endcase
        end
    end

    assign resp_ret = csr_wr && (csr_addr == C_RESP);

    always_ff @(posedge clk) begin
        if (rst || rst_trig) begin
            paused    <= 1'b0;
            ovf_flag  <= 1'b0;
            done_flag <= 1'b0;
            n_commit  <= '0;
            n_done    <= '0;
            n_resp    <= '0;
        end else begin
            if (csr_wr && csr_addr == C_CTRL) paused <= csr_wdata[K_PAUSE];

            if (commit && q_full && !rst_busy) ovf_flag <= 1'b1;
            else if (csr_wr && csr_addr == C_STATUS && csr_wdata[S_OVF]) ovf_flag <= 1'b0;

            if (done_evt) done_flag <= 1'b1;
            else if (csr_wr && csr_addr == C_STATUS && csr_wdata[S_DONE]) done_flag <= 1'b0;

            if (push && !q_full) n_commit <= n_commit + 1'b1;
            if (done_evt)        n_done   <= n_done + 1'b1;

            if (done_evt && !resp_ret) begin
                if (n_resp != LVL_MAX) n_resp <= n_resp + 1'b1;
            end else if (resp_ret && !done_evt) begin
                if (n_resp != '0) n_resp <= n_resp - 1'b1;
            end
        end
    end

    always_comb begin
        status          = '0;
        status[S_BUSY]  = !q_empty || (state != MV_IDLE);
        status[S_EMPTY] = q_empty;
        status[S_FULL]  = q_full;
        status[S_PAUSE] = paused;
        status[S_RST]   = rst_busy;
        status[S_DONE]  = done_flag;
        status[S_OVF]   = ovf_flag;
    end

    always_comb begin
        case (csr_addr)
            C_STATUS: csr_rdata = status;
            C_CTRL:   csr_rdata = {31'd0, paused};
            C_QLVL:   csr_rdata = 32'(q_count);
            C_RESP:   csr_rdata = 32'(n_resp);
            C_SEQ:    csr_rdata = {16'(n_done), 16'(n_commit)};
            default:  csr_rdata = '0;
        endcase
    end

    assign mv_valid     = (state == MV_OFFER);
    assign mv_abort     = rst_busy;
    assign mv_rd_addr   = exec_d.rd_addr;
    assign mv_wr_addr   = exec_d.wr_addr;
    assign mv_len       = exec_d.len;
    assign mv_burst_seq = exec_d.burst_seq;
    assign mv_rd_stride = exec_d.rd_stride;
    assign mv_wr_stride = exec_d.wr_stride;
    assign mv_flags     = exec_d.flags;

    a_r4_offer_hold: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && !mv_ready && !rst_trig) |=>
            (mv_valid && $stable(mv_rd_addr) && $stable(mv_len) && $stable(mv_flags)));

    a_r4_no_offer_before_done: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && mv_ready) |=> !mv_valid);

    a_r8_flushed: assert property (@(posedge clk) disable iff (rst)
        rst_busy |-> (q_count == '0 && !mv_valid));

    a_r5_busy: assert property (@(posedge clk) disable iff (rst)
        (q_count != '0 || mv_valid) |-> csr_rdata[S_BUSY] || csr_addr != C_STATUS);

    a_r9_no_push_in_reset: assert property (@(posedge clk) disable iff (rst)
        rst_busy |=> (q_count == '0));
endmodule

// File: tb/sim_sgd_dispatch.sv
module sim_sgd_dispatch;
    localparam int DEPTH = 4;
    localparam int RCYC  = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wr = 1'b0, dsc_wr = 1'b0;
    logic [2:0]  csr_addr = '0, dsc_addr = '0;
    logic [31:0] csr_wdata = '0, dsc_wdata = '0, csr_rdata;
    logic        mv_valid, mv_ready = 1'b0, mv_done = 1'b0, mv_abort;
    logic [63:0] mv_rd_addr, mv_wr_addr;
    logic [31:0] mv_len, mv_burst_seq;
    logic [15:0] mv_rd_stride, mv_wr_stride;
    logic [3:0]  mv_flags;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    sgd_dispatch #(.FIFO_DEPTH(DEPTH), .RST_CYCLES(RCYC)) u0 (
        .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .dsc_wr(dsc_wr), .dsc_addr(dsc_addr), .dsc_wdata(dsc_wdata),
        .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_done(mv_done), .mv_abort(mv_abort),
        .mv_rd_addr(mv_rd_addr), .mv_wr_addr(mv_wr_addr), .mv_len(mv_len),
        .mv_burst_seq(mv_burst_seq), .mv_rd_stride(mv_rd_stride), .mv_wr_stride(mv_wr_stride),
        .mv_flags(mv_flags)
    );

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [227:0] exp_out(input logic [7:0][31:0] w);
        return {w[5], w[0], w[6], w[1], w[2], w[3], w[4][31:16], w[4][15:0],
                w[7][13], w[7][12], w[7][9], w[7][8]};
    endfunction

    function automatic logic [227:0] act_out();
        return {mv_rd_addr, mv_wr_addr, mv_len, mv_burst_seq, mv_wr_stride, mv_rd_stride, mv_flags};
    endfunction

    // all tasks start and end at a falling edge
    task automatic csr_w(input logic [2:0] a, input logic [31:0] d);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic csr_r(input logic [2:0] a, output logic [31:0] d);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic dsc_w(input logic [2:0] a, input logic [31:0] d);
        dsc_wr = 1'b1; dsc_addr = a; dsc_wdata = d;
        @(negedge clk);
        dsc_wr = 1'b0;
    endtask

    task automatic put_desc(input logic [7:0][31:0] w);
        for (int i = 0; i < 8; i++) dsc_w(3'(i), w[i]);
    endtask

    task automatic rand_desc(output logic [7:0][31:0] w);
        for (int i = 0; i < 7; i++) w[i] = $urandom();
        w[7] = $urandom() | 32'h8000_0000;
    endtask

    // complete the current offer: optional ready delay, accept, then done
    task automatic serve(input string tag, input logic [227:0] exp, input int hold);
        for (int i = 0; i < hold; i++) begin
            chk({tag, " R4 held valid"}, mv_valid, 1'b1);
            chk({tag, " R4 held fields"}, act_out(), exp);
            @(negedge clk);
        end
        chk({tag, " R2 fields"}, act_out(), exp);
        mv_ready = 1'b1;
        @(negedge clk);
        mv_ready = 1'b0;
        chk({tag, " R4 valid drops after accept"}, mv_valid, 1'b0);
        mv_done = 1'b1;
        @(negedge clk);
        mv_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [7:0][31:0] w;
        logic [7:0][31:0] ws [3];
        int hi;
        void'($urandom(32'd20211));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        csr_r(3'd0, r); chk("R1 status", r, 32'h2);
        csr_r(3'd2, r); chk("R1 depth", r, 0);
        csr_r(3'd4, r); chk("R1 counts", r, 0);
        chk("R1 mv_valid", mv_valid, 1'b0);

        // R3 commit bit clear: nothing queued
        dsc_w(3'd7, 32'h0000_3300);
        csr_r(3'd2, r); chk("R3 no commit", r, 0);

        // R2/R3 directed descriptor, flags bits 8 and 13
        w = '{32'h8000_0100, 32'h0000_1234, 32'h7777_6666, 32'h0000_0040,
              32'h0000_0005, 32'h0003_0002, 32'hDDDD_0001, 32'hAAAA_0000};
        w[7] = 32'h8000_2100; w[6] = 32'h0000_00EE;
        put_desc(w);
        csr_r(3'd2, r); chk("R3 depth after commit", r, 1);
        chk("R4 not yet offered", mv_valid, 1'b0);
        @(negedge clk);
        chk("R4 offered", mv_valid, 1'b1);
        chk("R2 flags", mv_flags, 4'b1001);
        csr_r(3'd0, r); chk("R5 busy during offer", r[0], 1'b1);
        serve("dir", exp_out(w), 2);
        csr_r(3'd0, r); chk("R5 idle busy clear", r[0], 1'b0);
        chk("R7 done flag set", r[8], 1'b1);

        // R10 pause, R4 ordering
        csr_w(3'd1, 32'h1);
        for (int k = 0; k < 3; k++) begin rand_desc(ws[k]); put_desc(ws[k]); end
        csr_r(3'd2, r); chk("R10 queued while paused", r, 3);
        chk("R10 no offer while paused", mv_valid, 1'b0);
        csr_r(3'd0, r); chk("R10 pause status", r[5], 1'b1);
        csr_w(3'd1, 32'h0);
        for (int k = 0; k < 3; k++) begin
            if (!mv_valid) @(negedge clk);
            chk("R4 order valid", mv_valid, 1'b1);
            serve("order", exp_out(ws[k]), k);
        end
        csr_r(3'd4, r); chk("R11 commit count", r[15:0], 4);
        chk("R11 done count", r[31:16], 4);
        csr_r(3'd3, r); chk("R11 resp level", r, 4);
        csr_w(3'd3, 32'h0);
        csr_r(3'd3, r); chk("R11 resp retire", r, 3);

        // R6 overflow
        csr_w(3'd1, 32'h1);
        for (int k = 0; k < DEPTH + 1; k++) begin rand_desc(w); put_desc(w); end
        csr_r(3'd2, r); chk("R6 depth capped", r, DEPTH);
        csr_r(3'd0, r); chk("R6 overflow flag", r[9], 1'b1);
        chk("R6 full bit", r[2], 1'b1);
        csr_w(3'd0, 32'h3FF);
        csr_r(3'd0, r); chk("R7 sticky cleared", r[9:8], 2'b00);
        chk("R7 live bits kept", {r[6:5], r[2:0]}, 5'b01101);

        // R8 soft reset, R9 commit during reset dropped
        for (int i = 0; i < 7; i++) dsc_w(3'(i), $urandom());
        csr_w(3'd1, 32'h2);
        csr_r(3'd2, r); chk("R8 flushed", r, 0);
        dsc_w(3'd7, 32'h8000_0000);
        hi = 1;
        while (mv_abort && hi < 100) begin
            csr_r(3'd0, r);
            if (r[6] !== 1'b1) chk("R8 resetting bit", r[6], 1'b1);
            if (mv_valid !== 1'b0) chk("R8 valid low", mv_valid, 1'b0);
            @(negedge clk);
            hi++;
        end
        chk("R8 resetting length", hi - 1, RCYC - 1);
        csr_r(3'd0, r); chk("R8 status after reset", r, 32'h2);
        csr_r(3'd4, r); chk("R8 counters cleared", r, 0);
        csr_r(3'd2, r); chk("R9 commit in reset dropped", r, 0);
        @(negedge clk);
        chk("R9 no offer", mv_valid, 1'b0);
        csr_r(3'd0, r); chk("R9 no overflow", r[9], 1'b0);

        // random traffic
        for (int k = 0; k < 24; k++) begin
            rand_desc(w);
            put_desc(w);
            @(negedge clk);
            chk("R4 random offer", mv_valid, 1'b1);
            serve("rand", exp_out(w), int'($urandom_range(0, 3)));
        end
        csr_r(3'd4, r); chk("R11 random counts", r, {16'd24, 16'd24});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule